// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block models a byte-wide static memory in which the eight highest addresses hold a calendar clock instead of plain storage. The lowest of those eight addresses is a control byte. The other seven hold second, minute, hour, weekday, day of month, month and two-digit year, all in packed BCD with a 24-hour clock. Every other address is ordinary read/write storage. With `ADDR_W = 13` the array is 8K x 8, and the clock sits at 1FF8h..1FFFh. The default of 11 keeps the modelled array small.

The time is kept in hidden counters that advance on a single-cycle `tick` pulse, normally once per second. The seven visible clock bytes are ordinary cells. They are refreshed from the counters in the cycle after each tick. Two control bits suspend that refresh. The write bit lets the host load a new time, and clearing it copies the visible bytes into the counters. The read bit holds a stable snapshot while the counters keep running. The low six control bits are a calibration value that is only stored. While `pwr_fail` is high, every host write is dropped.

Top module: `bcd_clock_sram`

## Requirements
- R1: Writes to any address below the top eight store the byte. A read strobe (`sel`=1, `wr`=0) returns the byte on `rdata` in the cycle after the strobe.
- R2: The clock bytes are mapped by offset from the base of the top eight addresses: +0 control, +1 second, +2 minute, +3 hour, +4 weekday, +5 day of month, +6 month, +7 year. The control byte has bit 7 = write-freeze, bit 6 = read-freeze and bits 5:0 = calibration.
- R3: After reset the control byte reads 00h and the time reads year 00, month 01, date 01, weekday 01, 00:00:00.
- R4: Second rolls from 59 to 00 and carries into minute. Minute rolls from 59 to 00 and carries into hour. Hour rolls from 23 to 00 and advances the date.
- R5: When the date advances, the weekday advances too, wrapping from 7 to 1.
- R6: April, June, September and November end after day 30. All other months except February end after day 31. The next date is then 01 and the month advances.
- R7: February ends after day 29 when the BCD year is divisible by four, and after day 28 otherwise.
- R8: The month rolls from 12 to 01 and advances the year. The year rolls from 99 to 00.
- R9: When neither freeze bit is set, the visible clock bytes take the counter value in the cycle after a tick. A read strobe issued after that shows the new time.
- R10: While the write bit is set, ticks do not change the visible bytes, and host writes to them are kept. Writing the control byte with bit 7 clear while bit 7 was set loads the visible time into the counters.
- R11: While the read bit is set, the visible bytes are held but the counters keep counting. After the bit is cleared, the next tick shows every tick that occurred in the meantime.
- R12: Calibration bits 5:0 read back as written and do not stop the clock.
- R13: While `pwr_fail` is high, writes to storage, clock bytes and control are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Access strobe, one access per cycle |
| wr | input | 1 | 1 = write, 0 = read for this strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after a read strobe |
| tick | input | 1 | One-cycle time-advance pulse |
| pwr_fail | input | 1 | Supply out of tolerance; blocks writes |

## Verification
Read data appears one edge after the strobe. The bench drives every access on a falling edge and samples `rdata` on the next falling edge. A tick changes the hidden counters at its own edge, and the visible bytes one edge later. Each tick is held for one cycle before the next access starts, so any read made after a tick sees the refreshed value. The load triggered by clearing the write bit takes effect at the edge that captures that control write. The bench always issues its tick afterwards, so every table vector checks exactly one advance from a freshly loaded time.

// File: rtl/rtc_pkg.sv
// Shared types and BCD calendar helpers for the memory-mapped clock.
// Assumes all time fields hold valid packed BCD.
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
    } rtc_time_t;

    localparam int CTRL_WR_BIT = 7;
    localparam int CTRL_RD_BIT = 6;

    localparam rtc_time_t RTC_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                        dow: 8'h01, hour: 8'h00, minute: 8'h00,
                                        second: 8'h00};

    // Add one to a two-digit packed BCD value (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is a multiple of four when (2*tens + units) mod 4 is zero.
    function automatic logic leap_year(input logic [7:0] y);
        logic [1:0] s;
        s = {y[4], 1'b0} + y[1:0];
        return s == 2'd0;
    endfunction

    // Last valid day of a month, in BCD.
    function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_store.sv
// Plain byte storage for the non-clock addresses.
// Assumes the caller masks writes to the clock window and during power fail.
// Read data is registered: valid the cycle after rd_en.
module rtc_store #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Store a byte on a qualified write.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 8'h00;
        else if (rd_en) q <= mem[addr];
    end

endmodule

// File: rtl/rtc_counter.sv
// Hidden BCD calendar counters. They advance once per tick with
// second/minute/hour/date/month/year carries, month-length and leap-year
// correction. A load replaces the whole time and takes priority over a tick.
module rtc_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cnt
);
    logic c_sec, c_min, c_day, c_date, c_mon;
    rtc_time_t nxt;

    // Carry chain from seconds up to month.
    always_comb begin
        c_sec  = tick  && (cnt.second == 8'h59);
        c_min  = c_sec && (cnt.minute == 8'h59);
        c_day  = c_min && (cnt.hour   == 8'h23);
        c_date = c_day && (cnt.date   == last_date(cnt.month, cnt.year));
        c_mon  = c_date && (cnt.month == 8'h12);
    end

    // Next-time computation for one tick.
    always_comb begin
        nxt = cnt;
        if (tick)   nxt.second = c_sec ? 8'h00 : bcd_inc(cnt.second);
        if (c_sec)  nxt.minute = c_min ? 8'h00 : bcd_inc(cnt.minute);
        if (c_min)  nxt.hour   = c_day ? 8'h00 : bcd_inc(cnt.hour);
        if (c_day)  nxt.dow    = (cnt.dow == 8'h07) ? 8'h01 : bcd_inc(cnt.dow);
        if (c_day)  nxt.date   = c_date ? 8'h01 : bcd_inc(cnt.date);
        if (c_date) nxt.month  = c_mon ? 8'h01 : bcd_inc(cnt.month);
        if (c_mon)  nxt.year   = (cnt.year == 8'h99) ? 8'h00 : bcd_inc(cnt.year);
    end

    // Counter register: reset, load or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= RTC_RESET;
        else if (load) cnt <= load_val;
        else           cnt <= nxt;
    end

    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt.second == 8'h59) |=> cnt.second == 8'h00);

    assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt.second == 8'h59 && cnt.minute == 8'h59 && cnt.hour == 8'h23)
        |=> cnt.hour == 8'h00);

    assert_year_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt.second == 8'h59 && cnt.minute == 8'h59 && cnt.hour == 8'h23
         && cnt.date == 8'h31 && cnt.month == 8'h12 && cnt.year == 8'h99)
        |=> (cnt.year == 8'h00 && cnt.month == 8'h01 && cnt.date == 8'h01));

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

endmodule

// File: rtl/rtc_regs.sv
// Visible clock bytes and control byte. The visible time follows the
// counters one cycle after each tick unless a freeze bit is set. A host
// write wins over a refresh in the same cycle. Assumes wr_en already
// excludes power-fail writes.
module rtc_regs
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] idx,
    input  logic [7:0] wdata,
    input  rtc_time_t  cnt,
    output rtc_time_t  vis,
    output logic [7:0] ctrl,
    output logic       load
);
    logic pend;
    logic freeze;

    assign freeze = ctrl[CTRL_WR_BIT] | ctrl[CTRL_RD_BIT];
    // Clearing the write bit transfers the visible time into the counters.
    assign load   = wr_en && (idx == 3'd0) && ctrl[CTRL_WR_BIT] && !wdata[CTRL_WR_BIT];

    // Refresh, host writes and control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            vis  <= RTC_RESET;
            ctrl <= 8'h00;
        end else begin
            pend <= tick;
            if (pend && !freeze) vis <= cnt;
            if (wr_en && idx != 3'd0) vis[8*(int'(idx)-1) +: 8] <= wdata;
            if (wr_en && idx == 3'd0) ctrl <= wdata;
        end
    end

    // R10 and R11: a set freeze bit holds the visible bytes
    assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !(wr_en && idx != 3'd0)) |=> $stable(vis));

    assert_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !freeze && !(wr_en && idx != 3'd0)) |=> vis == $past(cnt));

    assert_ctrl_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == 3'd0) |=> ctrl == $past(wdata));

endmodule

// File: rtl/bcd_clock_sram.sv
// Top: byte memory whose top eight addresses are the calendar clock.
// Decodes the clock window, blocks writes during power fail, and returns
// registered read data one cycle after a read strobe.
module bcd_clock_sram
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              tick,
    input  logic              pwr_fail
);
    logic       in_clk;
    logic       host_wr;
    logic       host_rd;
    logic [2:0] idx;
    logic [7:0] store_q;
    logic [7:0] ctrl;
    logic       load;
    logic       hit_clk;
    logic [7:0] clk_q;
    rtc_time_t  cnt;
    rtc_time_t  vis;
    logic [63:0] clk_bytes;

    assign in_clk    = &addr[ADDR_W-1:3];
    assign idx       = addr[2:0];
    assign host_wr   = sel && wr && !pwr_fail;
    assign host_rd   = sel && !wr;
    assign clk_bytes = {vis, ctrl};

    rtc_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (host_wr && !in_clk),
        .rd_en (host_rd && !in_clk),
        .addr  (addr),
        .wdata (wdata),
        .q     (store_q)
    );

    rtc_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val (vis),
        .cnt      (cnt)
    );

    rtc_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_en (host_wr && in_clk),
        .idx   (idx),
        .wdata (wdata),
        .cnt   (cnt),
        .vis   (vis),
        .ctrl  (ctrl),
        .load  (load)
    );

    // Register the clock-window read and which source answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_clk <= 1'b0;
            clk_q   <= 8'h00;
        end else if (host_rd) begin
            hit_clk <= in_clk;
            clk_q   <= clk_bytes[8*int'(idx) +: 8];
        end
    end

    assign rdata = hit_clk ? clk_q : store_q;

    assert_pf_ctrl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && pwr_fail && in_clk && idx == 3'd0) |=> $stable(ctrl));

    assert_pf_time_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && pwr_fail && ctrl[CTRL_WR_BIT]) |=> $stable(vis));

endmodule

// File: tb/test_bcd_clock_sram.sv
`timescale 1ns/1ps
module test_bcd_clock_sram;
    localparam int ADDR_W = 11;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'((1 << ADDR_W) - 8);
    localparam int NV = 15;

    // {start time, expected after one tick}; each 56-bit field is
    // year month date dow hour minute second in BCD.
    localparam logic [111:0] VECS [NV] = '{
        112'h23051003123456_23051003123457,
        112'h23051003123459_23051003123500,
        112'h23051003125959_23051003130000,
        112'h23051007235959_23051101000000,
        112'h23043002235959_23050103000000,
        112'h23073101235959_23080102000000,
        112'h23013004235959_23013105000000,
        112'h24022803235959_24022904000000,
        112'h24022904235959_24030105000000,
        112'h23022802235959_23030103000000,
        112'h00022801235959_00022902000000,
        112'h23123107235959_24010101000000,
        112'h99123105235959_00010106000000,
        112'h12022801235959_12022902000000,
        112'h10022801235959_10030102000000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic tick = 1'b0;
    logic pwr_fail = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] rb;
    logic [55:0] tm;

    always #2 clk = ~clk;

    bcd_clock_sram #(.ADDR_W(ADDR_W)) i_bcd_clock_sram (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .pwr_fail(pwr_fail)
    );

    function automatic string vec_tag(input int i);
        if (i < 4)       return "R4/R5";
        else if (i < 7)  return "R6";
        else if (i < 11) return "R7";
        else if (i < 13) return "R8";
        else             return "R7";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
    endtask

    task automatic read_byte(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk); sel = 1'b0; d = rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic read_time(output logic [55:0] t);
        for (int k = 1; k <= 7; k++) begin
            logic [7:0] b;
            read_byte(BASE + ADDR_W'(k), b);
            t[8*(k-1) +: 8] = b;
        end
    endtask

    task automatic load_time(input logic [55:0] t);
        write_byte(BASE, 8'h80);
        for (int k = 1; k <= 7; k++) write_byte(BASE + ADDR_W'(k), t[8*(k-1) +: 8]);
        write_byte(BASE, 8'h00);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state
        read_byte(BASE, rb);
        check("R3 ctrl", rb, 8'h00);
        read_time(tm);
        check("R3 time", tm, 56'h00010101000000);

        // R1: plain storage at both ends of the ordinary range
        write_byte('0, 8'hA5);
        write_byte(BASE - 1, 8'h3C);
        write_byte(ADDR_W'(5), 8'h5A);
        read_byte('0, rb);
        check("R1 low", rb, 8'hA5);
        read_byte(BASE - 1, rb);
        check("R1 top plain", rb, 8'h3C);

        // R2/R9/R4-R8: calendar vectors, one tick each
        for (int i = 0; i < NV; i++) begin
            load_time(VECS[i][111:56]);
            pulse_tick();
            read_time(tm);
            check($sformatf("%s R2 R9 vec %0d", vec_tag(i), i), tm, VECS[i][55:0]);
        end

        // R12: calibration stored, clock keeps running
        load_time(56'h23051003120010);
        write_byte(BASE, 8'h2A);
        read_byte(BASE, rb);
        check("R12 cal", rb, 8'h2A);
        pulse_tick();
        read_byte(BASE + 1, rb);
        check("R12 running", rb, 8'h11);
        write_byte(BASE, 8'h00);

        // R11: read freeze holds the view, counters continue
        write_byte(BASE, 8'h40);
        pulse_tick();
        pulse_tick();
        read_byte(BASE + 1, rb);
        check("R11 held", rb, 8'h11);
        write_byte(BASE, 8'h00);
        pulse_tick();
        read_byte(BASE + 1, rb);
        check("R11 caught up", rb, 8'h14);

        // R10: write freeze holds host values, clearing loads them
        write_byte(BASE, 8'h80);
        write_byte(BASE + 1, 8'h45);
        pulse_tick();
        read_byte(BASE + 1, rb);
        check("R10 host value kept", rb, 8'h45);
        write_byte(BASE, 8'h00);
        pulse_tick();
        read_byte(BASE + 1, rb);
        check("R10 loaded", rb, 8'h46);

        // R13: power fail drops all writes
        pwr_fail = 1'b1;
        write_byte(ADDR_W'(5), 8'hEE);
        write_byte(BASE + 1, 8'h00);
        write_byte(BASE, 8'h80);
        pwr_fail = 1'b0;
        read_byte(ADDR_W'(5), rb);
        check("R13 storage", rb, 8'h5A);
        read_byte(BASE + 1, rb);
        check("R13 clock byte", rb, 8'h46);
        read_byte(BASE, rb);
        check("R13 ctrl", rb, 8'h00);
        pulse_tick();
        read_byte(BASE + 1, rb);
        check("R13 still running", rb, 8'h47);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule